// File: doc/BRIEF.md
# Four-Quadrant PWM Mode Decoder and Gate Steering

This block sits between the digitised control loop of a bidirectional flyback ring generator and its three gate drivers. Every clock it receives a signed reference sample, a signed error code, the value of a free-running ramp counter, an enable and a current-limit flag.

The signs of the reference and of the error pick one of four quadrants:

| Encoding | Reference | Power flow |
|---|---|---|
| 00 | reference >= 0 | forward |
| 01 | reference >= 0 | returned to the source |
| 10 | reference < 0 | forward |
| 11 | reference < 0 | returned to the source |

The magnitude of the error, capped just below half the ramp period, sets the width of a pulse that starts at ramp zero. The quadrant then routes that pulse, or a synchronous-rectifier drive, to one of three outputs:

- the primary switch;
- the p-channel secondary, which is active low;
- the n-channel secondary.

A range flag reports whether the commanded duty lies strictly between zero and one half.

The quadrant and the duty are taken once per ramp period, on the cycle where the ramp reads zero. A pulse is therefore never shortened or re-routed part way through. A current-limit event blanks all drive for the rest of the period. All outputs are registered: each output reflects the inputs sampled on the previous rising edge.

Top module: `quad_pwm_steer`

## Requirements
- R1: The quadrant is {reference < 0, error < 0}. In quadrant 00 the pulse goes to `gate_pri`. In quadrant 01 it goes to `gate_nch`. In quadrant 10 it goes to `gate_pri`. In quadrant 11 it goes to the p-channel output. Outputs with no role in the quadrant are held off.
- R2: The pulse is on while ramp < D. D = min(|error|, 127) for the default 8-bit ramp, so the duty never reaches 50 %.
- R3: Rectifier drive is on while ramp < 128 and the pulse is off. It goes to the p-channel output in quadrant 00 and to `gate_nch` in quadrant 10. No output is driven while ramp >= 128.
- R4: `gate_pch_n` is active low: 0 means the p-channel switch is on, and 1 is its off level.
- R5: While enable is low, `gate_pri` and `gate_nch` are 0 and `gate_pch_n` is 1 on the following cycle.
- R6: A high current-limit flag forces all gates off from that sample to the end of the ramp period. The blanking clears at the next ramp zero unless the flag is still high there.
- R7: The quadrant and D are captured only when ramp is 0. Error or reference changes during a period have no effect on the gates until the next ramp zero.
- R8: `duty_ok` is 1 exactly when 0 < |error| < 128, evaluated on the error sampled in the previous cycle. It is not affected by the capture of R7.
- R9: During reset `gate_pri`, `gate_nch` and `duty_ok` are 0 and `gate_pch_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Drive enable, active high |
| ilim | input | 1 | Current-limit flag, active high |
| ref_smp | input | 12 | Signed reference sample |
| err_code | input | 8 | Signed error-amplifier code |
| ramp | input | 8 | Ramp counter value, wraps at 255 |
| gate_pri | output | 1 | Primary switch drive, active high |
| gate_pch_n | output | 1 | P-channel secondary drive, active low |
| gate_nch | output | 1 | N-channel secondary drive, active high |
| duty_ok | output | 1 | Commanded duty strictly within (0, 0.5) |

## Verification
The properties assume three things about the inputs:

- the ramp counts up by one each cycle and wraps, so its upper half is always pulse-free;
- enable and the current-limit flag are defined from reset onward;
- the bench applies them only through the registered output path.

The stimulus keeps to these assumptions. It always walks the ramp through complete 0-to-255 periods, and it changes error, reference, enable and the limit flag only at the falling edge. Error changes inside a period are deliberate, to show that the captured value holds until the next ramp zero.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  // Quadrant code: {reference negative, power returned}
  typedef enum logic [1:0] {
    QM_SRC_POS = 2'b00,
    QM_RET_POS = 2'b01,
    QM_SRC_NEG = 2'b10,
    QM_RET_NEG = 2'b11
  } quad_mode_e;
endpackage

// File: rtl/quad_pwm_capture.sv
module quad_pwm_capture
  import quad_pwm_pkg::*;
#(
  parameter int RAMP_W = 8,
  parameter int ERR_W  = 8,
  parameter int REF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ilim,
  input  logic signed [REF_W-1:0] ref_smp,
  input  logic signed [ERR_W-1:0] err_code,
  input  logic [RAMP_W-1:0]       ramp,
  output quad_mode_e              cur_mode,
  output logic [RAMP_W-1:0]       cur_duty,
  output logic                    kill,
  output logic                    range_ok
);
  localparam int MAG_W = ERR_W + 1;
  localparam logic [MAG_W-1:0] CAP_M = MAG_W'(2**(RAMP_W-1) - 1);

  logic              wrap;
  logic [MAG_W-1:0]  mag;
  logic [RAMP_W-1:0] new_duty;
  quad_mode_e        new_mode;
  quad_mode_e        mode_q;
  logic [RAMP_W-1:0] duty_q;
  logic              kill_q;

  always_comb begin
    wrap     = (ramp == '0);
    mag      = err_code[ERR_W-1] ? ({1'b0, ~err_code} + MAG_W'(1))
                                 : {1'b0, err_code};
    new_duty = (mag > CAP_M) ? CAP_M[RAMP_W-1:0] : mag[RAMP_W-1:0];
    new_mode = quad_mode_e'({ref_smp[REF_W-1], err_code[ERR_W-1]});
    cur_mode = wrap ? new_mode : mode_q;
    cur_duty = wrap ? new_duty : duty_q;
    kill     = ilim | (kill_q & ~wrap);
    range_ok = (mag != '0) && (mag <= CAP_M);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= QM_SRC_POS;
      duty_q <= '0;
    end else if (wrap) begin
      mode_q <= new_mode;
      duty_q <= new_duty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kill_q <= 1'b0;
    else        kill_q <= kill;
  end
endmodule

// File: rtl/quad_pwm_gen.sv
module quad_pwm_gen #(
  parameter int RAMP_W = 8
) (
  input  logic [RAMP_W-1:0] ramp,
  input  logic [RAMP_W-1:0] duty,
  output logic              pwm,
  output logic              rect
);
  always_comb begin
    pwm  = (ramp < duty);
    rect = ~ramp[RAMP_W-1] & ~pwm;
  end
endmodule

// File: rtl/quad_gate_steer.sv
module quad_gate_steer
  import quad_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       kill,
  input  quad_mode_e mode,
  input  logic       pwm,
  input  logic       rect,
  input  logic       range_ok,
  output logic       gate_pri,
  output logic       gate_pch_n,
  output logic       gate_nch,
  output logic       duty_ok
);
  logic pri_d, pch_d, nch_d, live;

  always_comb begin
    pri_d = 1'b0;
    pch_d = 1'b0;
    nch_d = 1'b0;
    live  = en & ~kill;
    unique case (mode)
      QM_SRC_POS: begin pri_d = pwm; pch_d = rect; end
      QM_RET_POS: nch_d = pwm;
      QM_SRC_NEG: begin pri_d = pwm; nch_d = rect; end
      QM_RET_NEG: pch_d = pwm;
      default: ;
    endcase
    pri_d = pri_d & live;
    pch_d = pch_d & live;
    nch_d = nch_d & live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_pri   <= 1'b0;
      gate_pch_n <= 1'b1;
      gate_nch   <= 1'b0;
      duty_ok    <= 1'b0;
    end else begin
      gate_pri   <= pri_d;
      gate_pch_n <= ~pch_d;
      gate_nch   <= nch_d;
      duty_ok    <= range_ok;
    end
  end
endmodule

// File: rtl/quad_pwm_steer.sv
module quad_pwm_steer
  import quad_pwm_pkg::*;
#(
  parameter int RAMP_W = 8,
  parameter int ERR_W  = 8,
  parameter int REF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    ilim,
  input  logic signed [REF_W-1:0] ref_smp,
  input  logic signed [ERR_W-1:0] err_code,
  input  logic [RAMP_W-1:0]       ramp,
  output logic                    gate_pri,
  output logic                    gate_pch_n,
  output logic                    gate_nch,
  output logic                    duty_ok
);
  quad_mode_e        cur_mode;
  logic [RAMP_W-1:0] cur_duty;
  logic              kill, range_ok, pwm, rect;

  quad_pwm_capture #(.RAMP_W(RAMP_W), .ERR_W(ERR_W), .REF_W(REF_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ilim(ilim), .ref_smp(ref_smp),
    .err_code(err_code), .ramp(ramp), .cur_mode(cur_mode),
    .cur_duty(cur_duty), .kill(kill), .range_ok(range_ok)
  );

  quad_pwm_gen #(.RAMP_W(RAMP_W)) u_gen (
    .ramp(ramp), .duty(cur_duty), .pwm(pwm), .rect(rect)
  );

  quad_gate_steer u_steer (
    .clk(clk), .rst_n(rst_n), .en(en), .kill(kill), .mode(cur_mode),
    .pwm(pwm), .rect(rect), .range_ok(range_ok),
    .gate_pri(gate_pri), .gate_pch_n(gate_pch_n),
    .gate_nch(gate_nch), .duty_ok(duty_ok)
  );
endmodule

// File: rtl/quad_pwm_steer_chk.sv
module quad_pwm_steer_chk #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              ilim,
  input logic [RAMP_W-1:0] ramp,
  input logic              gate_pri,
  input logic              gate_pch_n,
  input logic              gate_nch
);
  AST_PRI_NCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_pri && gate_nch)); // R1

  AST_PRI_PCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_pri && !gate_pch_n)); // R3

  AST_UPPER_HALF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ramp[RAMP_W-1] |=> (!gate_pri && !gate_nch && gate_pch_n)); // R3

  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_pri && !gate_nch && gate_pch_n)); // R5

  AST_ILIM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ilim |=> (!gate_pri && !gate_nch && gate_pch_n)); // R6
endmodule

bind quad_pwm_steer quad_pwm_steer_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ilim(ilim), .ramp(ramp),
  .gate_pri(gate_pri), .gate_pch_n(gate_pch_n), .gate_nch(gate_nch)
);

// File: tb/quad_pwm_steer_tb.sv
module quad_pwm_steer_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic              ilim = 1'b0;
  logic signed [11:0] ref_smp = '0;
  logic signed [7:0]  err_code = '0;
  logic [7:0]        ramp = '0;
  logic gate_pri, gate_pch_n, gate_nch, duty_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic  pri, pch_n, nch, ok;
    string tag;
  } exp_t;
  exp_t sb[$];

  int  m_mode = 0;
  int  m_duty = 0;
  bit  m_kill = 1'b0;

  always #2 clk = ~clk;

  quad_pwm_steer u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ilim(ilim), .ref_smp(ref_smp),
    .err_code(err_code), .ramp(ramp), .gate_pri(gate_pri),
    .gate_pch_n(gate_pch_n), .gate_nch(gate_nch), .duty_ok(duty_ok)
  );

  task automatic check(input string tag, input logic [3:0] act,
                       input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pri,pch_n,nch,ok} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input bit e, input bit il, input int r, input int er,
                       input int rp, input string tag);
    exp_t x;
    int  mag;
    bit  wrap, kill, pwm, rect, pri, pch, nch;
    @(negedge clk);
    en = e; ilim = il; ref_smp = 12'(r); err_code = 8'(er); ramp = 8'(rp);
    mag  = (er < 0) ? -er : er;
    wrap = (rp == 0);
    if (wrap) begin
      m_mode = ((r < 0) ? 2 : 0) + ((er < 0) ? 1 : 0);
      m_duty = (mag > 127) ? 127 : mag;
    end
    kill   = il | (m_kill & !wrap);
    m_kill = kill;
    pwm  = (rp < m_duty);
    rect = (rp < 128) && !pwm;
    pri = 0; pch = 0; nch = 0;
    case (m_mode)
      0: begin pri = pwm; pch = rect; end
      1: nch = pwm;
      2: begin pri = pwm; nch = rect; end
      default: pch = pwm;
    endcase
    if (!e || kill) begin pri = 0; pch = 0; nch = 0; end
    x.pri = pri; x.pch_n = !pch; x.nch = nch;
    x.ok  = (mag > 0) && (mag < 128);
    x.tag = tag;
    sb.push_back(x);
  endtask

  // One full ramp period; error switches to er2 from step 100, ilim pulses at il_at
  task automatic period(input bit e, input int r, input int er, input int er2,
                        input int il_at, input string tag);
    for (int i = 0; i < 256; i++)
      apply(e, (i == il_at), r, (i >= 100) ? er2 : er, i, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      check(x.tag, {gate_pri, gate_pch_n, gate_nch, duty_ok},
            {x.pri, x.pch_n, x.nch, x.ok});
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", {gate_pri, gate_pch_n, gate_nch, duty_ok}, 4'b0100);
    @(negedge clk);
    rst_n = 1'b1;
    period(1, 100, 40, 40, -1, "R1 R2 R3 R4 quadrant 00");
    period(1, 0, -60, -60, -1, "R1 R2 quadrant 01");
    period(1, -5, 127, 127, -1, "R1 R3 quadrant 10");
    period(1, -300, -128, -128, -1, "R2 R4 R8 quadrant 11 capped");
    period(1, 50, 0, 0, -1, "R8 zero duty");
    period(1, 50, 30, 90, -1, "R7 mid-period change");
    period(1, -50, 20, -20, -1, "R7 sign change held");
    period(1, 50, 100, 100, 60, "R6 limit blanking");
    period(1, -50, 100, 100, 10, "R6 limit early");
    period(1, -50, 100, 100, -1, "R6 recovery");
    period(0, 50, 70, 70, -1, "R5 disabled");
    period(1, 50, 70, 70, -1, "R5 re-enabled");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule